// File: doc/BRIEF.md
# Register-indirect jump-and-link unit

This block recognises one 32-bit instruction, a compact jump that reads its target from a register and can write a return address into a second register. For each instruction the front end presents, the block reports whether the word matches. On a match it also gives the register index and data for the return-address write, the redirected fetch address, the instruction-set mode that fetch should use from then on, and whether that next fetch must take an address error. The register file supplies the value of the source register. The caller writes the link value back into the register file and routes the error into its exception path.

Two instruction sets can be present. One is compressed and allows 2-byte alignment. The other uses only 4-byte-aligned words. A static configuration input states whether the 4-byte set exists. Bit 0 of the target register carries the requested mode. Mode value 1 means the compressed set and 0 means the 4-byte set. The jump has no delay slot. A small registered stage holds the fetch PC, the mode and the pending error flag. It can also load a non-jump next PC from the sequencer.

Top module: `jlr_unit`

## Requirements
- R1: `hit` is 1 only when `instr_valid` is 1 and the word has bits [31:26] = 000000, bits [15:6] = 0000111100 and bits [5:0] = 111100. Any other word gives `hit` = 0.
- R2: On a hit, `link_idx` equals instruction bits [25:21] and `link_data` equals `cur_pc + 4`.
- R3: `link_we` is 1 only on a hit whose link index (bits [25:21]) is non-zero. Register 0 is never written, so an index of 0 acts as a plain register jump.
- R4: The target comes from `rs_val`, the value read for bits [20:16] before any link write. A word with the same index in both fields therefore jumps to the old register content.
- R5: With `dual_isa` = 0, `redirect_pc` is `rs_val` with bit 0 cleared, `new_mode` is 1, and `addr_err` is 1 exactly when `rs_val[0]` is 0.
- R6: With `dual_isa` = 1, `new_mode` equals `rs_val[0]`, `redirect_pc` is `rs_val` with bit 0 cleared, and `addr_err` is 1 exactly when `rs_val[0]` is 0 and `rs_val[1]` is 1.
- R7: After a hit, the next rising edge loads `pc_q`, `mode_q` and `fetch_err_q` from `redirect_pc`, `new_mode` and `addr_err`, and `redirect_q` is 1 for that one cycle. A hit overrides `seq_en` in the same cycle, so the sequential successor of the jump is never loaded.
- R8: With `seq_en` = 1 and no hit, the next edge loads `pc_q` from `seq_pc`, clears `fetch_err_q`, and leaves `mode_q` unchanged.
- R9: With neither a hit nor `seq_en`, `pc_q`, `mode_q` and `fetch_err_q` hold their values and `redirect_q` is 0.
- R10: While `rst_n` is 0, `pc_q` is `RESET_VEC`, `mode_q` is 1, and `fetch_err_q` and `redirect_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| dual_isa | input | 1 | Static: 1 when the 4-byte instruction set is also present |
| instr_valid | input | 1 | `instr` holds a real instruction this cycle |
| instr | input | 32 | Instruction word |
| cur_pc | input | XLEN | Address of `instr` |
| rs_val | input | XLEN | Register-file value for the source field |
| seq_en | input | 1 | Non-jump PC update request |
| seq_pc | input | XLEN | PC for the non-jump update |
| hit | output | 1 | Instruction decoded as the jump |
| link_idx | output | 5 | Register index for the return address |
| link_data | output | XLEN | Return address |
| link_we | output | 1 | Return-address write enable |
| redirect_pc | output | XLEN | Jump target with bit 0 cleared |
| new_mode | output | 1 | Mode requested for the target |
| addr_err | output | 1 | Target fetch must fault |
| pc_q | output | XLEN | Registered fetch PC |
| mode_q | output | 1 | Registered mode |
| fetch_err_q | output | 1 | Registered pending fetch error |
| redirect_q | output | 1 | One-cycle pulse after a jump is taken |

## Verification
The hardest case to reach is the 4-byte-set fault with `dual_isa` = 1. It needs mode bit 0 clear and address bit 1 set in the same target, and a uniformly random register value gives that in only a quarter of draws. A word that merely looks like the jump matches by chance almost never. The stimulus therefore builds most words from the exact encoding with random register fields. It chooses the low two target bits directly, so that all four combinations occur under both configuration values. Directed steps add the cases with equal source and link indices and with link index 0, and a cycle where a hit and a sequential update arrive together.

// File: rtl/jlr_pkg.sv
package jlr_pkg;
  localparam logic [5:0]  MAJOR_OP = 6'b000000;
  localparam logic [9:0]  MINOR_OP = 10'b0000111100;
  localparam logic [5:0]  POOL_OP  = 6'b111100;
  localparam logic        MODE_CMP = 1'b1;  // compressed set
  localparam int unsigned REG_IDX_W = 5;

  typedef struct packed {
    logic                 match;
    logic [REG_IDX_W-1:0] link_idx;
    logic [REG_IDX_W-1:0] src_idx;
  } dec_t;
endpackage

// File: rtl/jlr_decode.sv
module jlr_decode
  import jlr_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  always_comb begin
    dec.match    = (instr[31:26] == MAJOR_OP) &&
                   (instr[15:6]  == MINOR_OP) &&
                   (instr[5:0]   == POOL_OP);
    dec.link_idx = instr[25:21];
    dec.src_idx  = instr[20:16];
  end
endmodule

// File: rtl/jlr_target.sv
module jlr_target #(
  parameter int unsigned XLEN = 32
) (
  input  logic            dual_isa,
  input  logic [XLEN-1:0] rs_val,
  output logic [XLEN-1:0] tgt_pc,
  output logic            tgt_mode,
  output logic            tgt_err
);
  always_comb begin
    tgt_pc = {rs_val[XLEN-1:1], 1'b0};
    if (dual_isa) begin
      tgt_mode = rs_val[0];
      tgt_err  = !rs_val[0] && rs_val[1];
    end else begin
      tgt_mode = jlr_pkg::MODE_CMP;
      tgt_err  = !rs_val[0];
    end
  end
endmodule

// File: rtl/jlr_pc_stage.sv
module jlr_pc_stage #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jump_en,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic            tgt_mode,
  input  logic            tgt_err,
  input  logic            seq_en,
  input  logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] pc_q,
  output logic            mode_q,
  output logic            err_q,
  output logic            redir_q
);
  logic            pc_ce;
  logic [XLEN-1:0] pc_d;
  logic            mode_d;
  logic            err_d;

  always_comb begin
    pc_ce  = jump_en || seq_en;
    pc_d   = pc_q;
    mode_d = mode_q;
    err_d  = err_q;
    if (jump_en) begin
      pc_d   = tgt_pc;
      mode_d = tgt_mode;
      err_d  = tgt_err;
    end else if (seq_en) begin
      pc_d   = seq_pc;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_VEC;
      mode_q <= jlr_pkg::MODE_CMP;
      err_q  <= 1'b0;
    end else if (pc_ce) begin
      pc_q   <= pc_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_q <= 1'b0;
    else        redir_q <= jump_en;
  end
endmodule

// File: rtl/jlr_unit.sv
module jlr_unit
  import jlr_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_isa,
  input  logic                 instr_valid,
  input  logic [31:0]          instr,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [XLEN-1:0]      rs_val,
  input  logic                 seq_en,
  input  logic [XLEN-1:0]      seq_pc,
  output logic                 hit,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_data,
  output logic                 link_we,
  output logic [XLEN-1:0]      redirect_pc,
  output logic                 new_mode,
  output logic                 addr_err,
  output logic [XLEN-1:0]      pc_q,
  output logic                 mode_q,
  output logic                 fetch_err_q,
  output logic                 redirect_q
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  dec_t dec;

  jlr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  jlr_target #(.XLEN(XLEN)) u_tgt (
    .dual_isa (dual_isa),
    .rs_val   (rs_val),
    .tgt_pc   (redirect_pc),
    .tgt_mode (new_mode),
    .tgt_err  (addr_err)
  );

  always_comb begin
    hit       = instr_valid && dec.match;
    link_idx  = dec.link_idx;
    link_data = cur_pc + INSN_BYTES;
    link_we   = hit && (dec.link_idx != '0);
  end

  jlr_pc_stage #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .jump_en  (hit),
    .tgt_pc   (redirect_pc),
    .tgt_mode (new_mode),
    .tgt_err  (addr_err),
    .seq_en   (seq_en),
    .seq_pc   (seq_pc),
    .pc_q     (pc_q),
    .mode_q   (mode_q),
    .err_q    (fetch_err_q),
    .redir_q  (redirect_q)
  );
endmodule

// File: rtl/jlr_unit_chk.sv
module jlr_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dual_isa,
  input logic [XLEN-1:0] rs_val,
  input logic            seq_en,
  input logic [XLEN-1:0] seq_pc,
  input logic            hit,
  input logic [4:0]      link_idx,
  input logic            link_we,
  input logic [XLEN-1:0] redirect_pc,
  input logic            new_mode,
  input logic            addr_err,
  input logic [XLEN-1:0] pc_q,
  input logic            mode_q,
  input logic            fetch_err_q,
  input logic            redirect_q
);
  // R3
  zero_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (hit && link_idx != 5'd0));

  // R5
  single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !dual_isa) |-> (new_mode && addr_err == !rs_val[0]));

  // R6
  dual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dual_isa) |-> (new_mode == rs_val[0] &&
                           addr_err == (!rs_val[0] && rs_val[1])));

  // R7
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (redirect_q && pc_q == $past(redirect_pc) &&
             mode_q == $past(new_mode) && fetch_err_q == $past(addr_err)));

  // R8
  seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !hit) |=> (!fetch_err_q && !redirect_q &&
                          pc_q == $past(seq_pc) && $stable(mode_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en && !hit) |=> ($stable(pc_q) && $stable(mode_q) &&
                           $stable(fetch_err_q) && !redirect_q));
endmodule

bind jlr_unit jlr_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/jlr_unit_tb.sv
module jlr_unit_tb;
  localparam int          CLK_P = 10;
  localparam logic [31:0] RVEC  = 32'h0000_1001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dual_isa, instr_valid, seq_en;
  logic [31:0] instr, cur_pc, rs_val, seq_pc;
  logic        hit, link_we, new_mode, addr_err, mode_q, fetch_err_q, redirect_q;
  logic [4:0]  link_idx;
  logic [31:0] link_data, redirect_pc, pc_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_pc;
  logic        m_mode, m_err;

  always #(CLK_P/2) clk = ~clk;

  jlr_unit #(.XLEN(32), .RESET_VEC(RVEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .dual_isa(dual_isa), .instr_valid(instr_valid),
    .instr(instr), .cur_pc(cur_pc), .rs_val(rs_val), .seq_en(seq_en),
    .seq_pc(seq_pc), .hit(hit), .link_idx(link_idx), .link_data(link_data),
    .link_we(link_we), .redirect_pc(redirect_pc), .new_mode(new_mode),
    .addr_err(addr_err), .pc_q(pc_q), .mode_q(mode_q),
    .fetch_err_q(fetch_err_q), .redirect_q(redirect_q)
  );

  function automatic logic [31:0] enc(input logic [4:0] rt, input logic [4:0] rs);
    return {6'b000000, rt, rs, 10'b0000111100, 6'b111100};
  endfunction

  function automatic logic is_jump(input logic [31:0] w);
    return w[31:26] == 6'd0 && w[15:6] == 10'b0000111100 && w[5:0] == 6'b111100;
  endfunction

  function automatic logic exp_err(input logic dual, input logic [31:0] t);
    return dual ? (!t[0] && t[1]) : !t[0];
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction cycle: drive, check combinational, clock, check registered
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] pc,
                      input logic [31:0] rv, input logic se, input logic [31:0] sp);
    logic eh;
    @(negedge clk);
    instr_valid = v; instr = w; cur_pc = pc; rs_val = rv; seq_en = se; seq_pc = sp;
    #1;
    eh = v && is_jump(w);
    chk(hit == eh, "R1 hit", {31'd0, hit}, {31'd0, eh});
    chk(link_we == (eh && w[25:21] != 5'd0), "R3 link_we", {31'd0, link_we},
        {31'd0, eh && w[25:21] != 5'd0});
    if (eh) begin
      chk(link_idx == w[25:21], "R2 link_idx", {27'd0, link_idx}, {27'd0, w[25:21]});
      chk(link_data == pc + 32'd4, "R2 link_data", link_data, pc + 32'd4);
      chk(redirect_pc == {rv[31:1], 1'b0}, "R4 target", redirect_pc, {rv[31:1], 1'b0});
      if (dual_isa) begin
        chk(new_mode == rv[0], "R6 mode", {31'd0, new_mode}, {31'd0, rv[0]});
        chk(addr_err == exp_err(1'b1, rv), "R6 err", {31'd0, addr_err},
            {31'd0, exp_err(1'b1, rv)});
      end else begin
        chk(new_mode == 1'b1, "R5 mode", {31'd0, new_mode}, 32'd1);
        chk(addr_err == exp_err(1'b0, rv), "R5 err", {31'd0, addr_err},
            {31'd0, exp_err(1'b0, rv)});
      end
      m_pc = {rv[31:1], 1'b0};
      m_mode = dual_isa ? rv[0] : 1'b1;
      m_err = exp_err(dual_isa, rv);
    end else if (se) begin
      m_pc = sp;
      m_err = 1'b0;
    end
    @(posedge clk); #1;
    chk(pc_q == m_pc, eh ? "R7 pc" : (se ? "R8 pc" : "R9 pc"), pc_q, m_pc);
    chk(mode_q == m_mode, eh ? "R7 mode" : "R9 mode", {31'd0, mode_q}, {31'd0, m_mode});
    chk(fetch_err_q == m_err, eh ? "R7 err" : (se ? "R8 err" : "R9 err"),
        {31'd0, fetch_err_q}, {31'd0, m_err});
    chk(redirect_q == eh, "R7 pulse", {31'd0, redirect_q}, {31'd0, eh});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    rst_n = 1'b0; dual_isa = 1'b0; instr_valid = 1'b0; instr = '0;
    cur_pc = '0; rs_val = '0; seq_en = 1'b0; seq_pc = '0;
    #(CLK_P * 3);
    // R10 reset values
    chk(pc_q == RVEC, "R10 pc", pc_q, RVEC);
    chk(mode_q == 1'b1, "R10 mode", {31'd0, mode_q}, 32'd1);
    chk(fetch_err_q == 1'b0, "R10 err", {31'd0, fetch_err_q}, 32'd0);
    chk(redirect_q == 1'b0, "R10 pulse", {31'd0, redirect_q}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    m_pc = RVEC; m_mode = 1'b1; m_err = 1'b0;

    // directed corners
    step(1'b1, enc(5'd7, 5'd7), 32'h100, 32'h2001, 1'b0, 0);   // R4 rs==rt, R5 ok
    step(1'b1, enc(5'd0, 5'd3), 32'h200, 32'h3000, 1'b0, 0);   // R3 rt=0, R5 err
    step(1'b0, 32'h0, 0, 0, 1'b1, 32'h400);                    // R8 clears err
    step(1'b1, enc(5'd1, 5'd2), 32'h0, 32'h80, 1'b1, 32'h4);   // R7 hit beats seq
    step(1'b1, enc(5'd1, 5'd2) ^ 32'h40, 32'h0, 32'h5, 1'b0, 0);// R1 minor off by one bit
    step(1'b0, enc(5'd4, 5'd2), 32'h0, 32'h5, 1'b0, 0);        // R1 invalid, R9 hold
    dual_isa = 1'b1;
    step(1'b1, enc(5'd31, 5'd9), 32'hFFFF_FFFC, 32'h1002, 1'b0, 0); // R6 err, R2 wrap
    step(1'b1, enc(5'd31, 5'd9), 32'h10, 32'h1004, 1'b0, 0);   // R6 4-byte ok
    step(1'b1, enc(5'd5, 5'd9), 32'h10, 32'h1003, 1'b0, 0);    // R6 compressed

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w, rv;
      if (i % 150 == 0) dual_isa = $urandom % 2;
      rv = $urandom;
      rv[1:0] = 2'($urandom % 4);
      case ($urandom % 4)
        0:       w = $urandom;
        1:       w = enc(5'($urandom), 5'($urandom)) ^ (32'd1 << ($urandom % 32));
        default: w = enc(5'($urandom), 5'($urandom));
      endcase
      step(($urandom % 8) != 0, w, $urandom & ~32'h1, rv, ($urandom % 3) == 0, $urandom);
    end

    @(negedge clk); rst_n = 1'b0; #1;
    chk(pc_q == RVEC && mode_q && !fetch_err_q, "R10 re-reset", pc_q, RVEC);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule